// File: doc/BRIEF.md
# Synthesizer Reference and Divider Core

This block is the digital counting heart of a phase-locked frequency synthesizer. A reference divider turns the crystal-rate system clock into a short comparison pulse. A programmable divider counts rising edges of the prescaled RF signal and emits its own pulse once per divisor. A two-flip-flop phase-frequency comparator turns the two pulse trains into pump-up and pump-down requests, and a lock detector watches how long those requests last.

One step-size select input changes two things together. When it is high, the comparison rate is the clock divided by 512 and the divisor keeps only its low 14 bits. When it is low, the rate is the clock divided by 1024 and all 15 divisor bits count. A pump-disable input silences both requests at the outputs. The lock flag is presented as an output enable: asserted while locked, released while out of lock.

The prescaled RF signal is sampled in the clock domain, so it must run slower than half the clock rate. A divisor written mid-count waits for the next reload.

Top module: `synth_core`

## Requirements
- R1: `fref_o` is a one-cycle pulse that first appears after the 512th rising clock edge following reset, then every 512 edges while `mode_i` is 1. With `mode_i` at 0 the count is 1024 edges.
- R2: `rf_i` passes through a two-stage synchronizer. Every rising edge of `rf_i` is counted, and a counted edge that completes a divide cycle gives a one-cycle `fdiv_o` pulse after the third clock edge at which `rf_i` is first sampled high. The first counted edge after reset completes a cycle.
- R3: With `mode_i` at 1, bit 14 of `div_i` is ignored and the divisor is `div_i[13:0]`. With `mode_i` at 0, the divisor is `div_i[14:0]`.
- R4: A divisor value of 0 or 1 divides by 2.
- R5: `div_i` is sampled only when a divide cycle completes. A change in the middle of a cycle leaves that cycle's length unchanged.
- R6: The comparator works on internal up and down states. An `fref_o` pulse sets the up state on the next edge, and an `fdiv_o` pulse sets the down state on the next edge. An edge that would leave both set clears both, so coincident pulses produce neither request. `up_o` and `dn_o` show these states while the pump is enabled.
- R7: While `pump_dis_i` is 1, `up_o` and `dn_o` are 0. The comparator keeps running underneath, so the requests return as soon as the pump is enabled again.
- R8: At each `fref_o` pulse, a comparison period closes. `lock_oe_o` goes to 1 after 4 consecutive closed periods with no violation. A violation is any cycle in which up or down is in its third or later consecutive active cycle.
- R9: A violation clears the count of clean periods, so `lock_oe_o` is 0 on the cycle after it. Requests of 2 cycles are tolerated; requests of 3 cycles are not.
- R10: While `rst_i` is 1, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal-rate reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rf_i | input | 1 | Prescaled RF signal, sampled in the clock domain |
| div_i | input | 15 | Divisor word |
| mode_i | input | 1 | 1: divide by 512 with a 14-bit divisor; 0: divide by 1024 with a 15-bit divisor |
| pump_dis_i | input | 1 | Forces both pump requests inactive |
| fref_o | output | 1 | Divided reference pulse |
| fdiv_o | output | 1 | Divided RF pulse |
| up_o | output | 1 | Pump-up request |
| dn_o | output | 1 | Pump-down request |
| lock_oe_o | output | 1 | Lock flag drive enable; 0 means released (out of lock) |

## Verification
The two pulse trains can land in the same cycle. The bench provokes this by starting the RF edge train exactly three cycles before the first reference pulse, so that in steady state the comparator must cancel both requests at once.

A request that stretches into a third cycle can also close a comparison period. To provoke this, the RF start is swept across offsets from -4 to +4 cycles around alignment. The bench then judges every output on every cycle against a reference model, and checks lock directly at offsets of 2 and 3 cycles.

// File: rtl/synth_pkg.sv
package synth_pkg;

    // Step-size select encoding as seen on the mode input
    typedef enum logic {
        STEP_FINE   = 1'b0,   // long reference period, full-width divisor
        STEP_COARSE = 1'b1    // short reference period, top divisor bit dropped
    } step_mode_e;

    // Depth of the RF sampling chain: two synchronizer stages plus one
    // history stage for edge detection
    localparam int RF_CHAIN = 3;

endpackage

// File: rtl/synth_ref_div.sv
module synth_ref_div
    import synth_pkg::*;
#(
    parameter int BASE_LOG2 = 9
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic mode_i,
    output logic pulse_o
);

    localparam int CW = BASE_LOG2 + 1;
    localparam logic [CW-1:0] LAST_COARSE = {1'b0, {BASE_LOG2{1'b1}}};
    localparam logic [CW-1:0] LAST_FINE   = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pulse;
    } ref_st_t;

    ref_st_t   st_d, st_q;
    logic [CW-1:0] last;

    always_comb begin
        last = (step_mode_e'(mode_i) == STEP_COARSE) ? LAST_COARSE : LAST_FINE;
        st_d       = st_q;
        st_d.pulse = (st_q.cnt == last);
        st_d.cnt   = (st_q.cnt >= last) ? '0 : st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    // the reference pulse never lasts two cycles
    p_ref_single_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.pulse |=> !st_q.pulse);

    // a pulse always coincides with a freshly wrapped count
    p_ref_wrap_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.pulse |-> (st_q.cnt == '0));

endmodule

// File: rtl/synth_n_div.sv
module synth_n_div
    import synth_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             rf_i,
    input  logic             mode_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             pulse_o
);

    typedef struct packed {
        logic [RF_CHAIN-1:0] chain;
        logic [DIV_W-1:0]    cnt;
        logic                pulse;
    } ndiv_st_t;

    ndiv_st_t          st_d, st_q;
    logic              rise;
    logic [DIV_W-1:0]  eff;
    logic [DIV_W-1:0]  reload;

    always_comb begin
        // divisor actually in force for the next cycle
        eff = div_i;
        if (step_mode_e'(mode_i) == STEP_COARSE) eff[DIV_W-1] = 1'b0;
        reload = (eff < DIV_W'(2)) ? DIV_W'(1) : eff - DIV_W'(1);

        rise = st_q.chain[1] & ~st_q.chain[2];

        st_d       = st_q;
        st_d.chain = {st_q.chain[RF_CHAIN-2:0], rf_i};
        st_d.pulse = 1'b0;
        if (rise) begin
            if (st_q.cnt == '0) begin
                st_d.pulse = 1'b1;
                st_d.cnt   = reload;
            end else begin
                st_d.cnt   = st_q.cnt - DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    // the count only moves on a detected RF edge
    p_cnt_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !rise |=> $stable(st_q.cnt));

    // minimum divisor of two keeps pulses apart
    p_pulse_single_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.pulse |=> !st_q.pulse);

    // coarse mode never loads the dropped top bit
    p_load_narrow_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (rise && st_q.cnt == '0 && mode_i) |=> !st_q.cnt[DIV_W-1]);

    // a completed cycle is reported on the following edge
    p_pulse_follows_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (rise && st_q.cnt == '0) |=> st_q.pulse);

endmodule

// File: rtl/synth_pfd.sv
module synth_pfd (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ref_i,
    input  logic fb_i,
    output logic up_o,
    output logic dn_o
);

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_st_t;

    pfd_st_t st_d, st_q;

    always_comb begin
        st_d.up = st_q.up | ref_i;
        st_d.dn = st_q.dn | fb_i;
        if (st_d.up && st_d.dn) begin
            st_d.up = 1'b0;
            st_d.dn = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign up_o = st_q.up;
    assign dn_o = st_q.dn;

    p_no_overlap_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !(st_q.up && st_q.dn));

    p_up_set_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (ref_i && !fb_i && !st_q.dn) |=> st_q.up);

    p_cancel_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.up && fb_i) |=> (!st_q.up && !st_q.dn));

endmodule

// File: rtl/synth_lock.sv
module synth_lock #(
    parameter int LOCK_PERIODS = 4,
    parameter int LOCK_WIDTH   = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ref_i,
    input  logic up_i,
    input  logic dn_i,
    output logic lock_o
);

    localparam int WW = $clog2(LOCK_WIDTH + 1);
    localparam int GW = $clog2(LOCK_PERIODS + 1);

    typedef struct packed {
        logic [WW-1:0] wid;    // prior consecutive active cycles
        logic [GW-1:0] good;   // clean periods in a row
        logic          bad;    // current period has seen a violation
    } lock_st_t;

    lock_st_t st_d, st_q;
    logic     active;
    logic     viol;

    always_comb begin
        active = up_i | dn_i;
        viol   = active && (st_q.wid >= WW'(LOCK_WIDTH));

        st_d = st_q;
        if (!active)    st_d.wid = '0;
        else if (!viol) st_d.wid = st_q.wid + WW'(1);

        if (ref_i) begin
            st_d.bad = 1'b0;
            if (st_q.bad || viol)                    st_d.good = '0;
            else if (st_q.good != GW'(LOCK_PERIODS)) st_d.good = st_q.good + GW'(1);
        end else begin
            st_d.bad = st_q.bad | viol;
            if (viol) st_d.good = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign lock_o = (st_q.good == GW'(LOCK_PERIODS));

    p_lock_drop_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        viol |=> !lock_o);

    p_lock_rise_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(lock_o) |-> $past(ref_i));

endmodule

// File: rtl/synth_core.sv
module synth_core
    import synth_pkg::*;
#(
    parameter int REF_BASE_LOG2 = 9,
    parameter int DIV_W         = 15,
    parameter int LOCK_PERIODS  = 4,
    parameter int LOCK_WIDTH    = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             rf_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             mode_i,
    input  logic             pump_dis_i,
    output logic             fref_o,
    output logic             fdiv_o,
    output logic             up_o,
    output logic             dn_o,
    output logic             lock_oe_o
);

    logic fref;
    logic fdiv;
    logic up_raw;
    logic dn_raw;

    synth_ref_div #(.BASE_LOG2(REF_BASE_LOG2)) u_ref (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .mode_i  (mode_i),
        .pulse_o (fref)
    );

    synth_n_div #(.DIV_W(DIV_W)) u_ndiv (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .rf_i    (rf_i),
        .mode_i  (mode_i),
        .div_i   (div_i),
        .pulse_o (fdiv)
    );

    synth_pfd u_pfd (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .ref_i (fref),
        .fb_i  (fdiv),
        .up_o  (up_raw),
        .dn_o  (dn_raw)
    );

    synth_lock #(
        .LOCK_PERIODS (LOCK_PERIODS),
        .LOCK_WIDTH   (LOCK_WIDTH)
    ) u_lock (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ref_i  (fref),
        .up_i   (up_raw),
        .dn_i   (dn_raw),
        .lock_o (lock_oe_o)
    );

    assign fref_o = fref;
    assign fdiv_o = fdiv;
    assign up_o   = up_raw & ~pump_dis_i;
    assign dn_o   = dn_raw & ~pump_dis_i;

endmodule

// File: tb/tb_synth_core.sv
module tb_synth_core;

    localparam int DIV_W = 15;
    localparam int RF_P  = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rf_in = 1'b0;
    logic             mode = 1'b1;
    logic             pump_dis = 1'b0;
    logic [DIV_W-1:0] div = 15'd128;
    logic             fref_o, fdiv_o, up_o, dn_o, lock_oe_o;

    always #2 clk = ~clk;

    synth_core dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .rf_i       (rf_in),
        .div_i      (div),
        .mode_i     (mode),
        .pump_dis_i (pump_dis),
        .fref_o     (fref_o),
        .fdiv_o     (fdiv_o),
        .up_o       (up_o),
        .dn_o       (dn_o),
        .lock_oe_o  (lock_oe_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // reference model, advanced on every clock edge
    int m_cyc, m_rcnt, m_ncnt, m_wid, m_good;
    bit m_bad, m_fref, m_fdiv, m_up, m_dn;
    bit h0, h1, h2, h3;

    always @(posedge clk) begin
        if (rst) begin
            m_cyc = 0; m_rcnt = 0; m_ncnt = 0; m_wid = 0; m_good = 0;
            m_bad = 0; m_fref = 0; m_fdiv = 0; m_up = 0; m_dn = 0;
            h0 = 0; h1 = 0; h2 = 0; h3 = 0;
        end else begin : mdl
            int ratio, eff;
            bit rise, nf, nd, u, d, act, viol;
            m_cyc = m_cyc + 1;
            h3 = h2; h2 = h1; h1 = h0; h0 = rf_in;
            rise = h2 && !h3;
            ratio = mode ? 512 : 1024;                    // R1
            eff = mode ? int'(div[13:0]) : int'(div);      // R3
            if (eff < 2) eff = 2;                          // R4
            nf = (m_rcnt == ratio - 1);
            m_rcnt = (m_rcnt >= ratio - 1) ? 0 : m_rcnt + 1;
            nd = 0;
            if (rise) begin                                // R2, R5
                if (m_ncnt == 0) begin nd = 1; m_ncnt = eff - 1; end
                else m_ncnt = m_ncnt - 1;
            end
            u = m_up | m_fref;                             // R6
            d = m_dn | m_fdiv;
            if (u && d) begin u = 0; d = 0; end
            act = m_up | m_dn;                             // R8, R9
            viol = act && (m_wid >= 2);
            if (!act) m_wid = 0; else if (!viol) m_wid = m_wid + 1;
            if (m_fref) begin
                if (m_bad || viol) m_good = 0;
                else if (m_good < 4) m_good = m_good + 1;
                m_bad = 0;
            end else begin
                m_bad = m_bad | viol;
                if (viol) m_good = 0;
            end
            m_fref = nf; m_fdiv = nd; m_up = u; m_dn = d;
        end
    end

    bit rf_en = 0;
    int rf_start = 0;
    int fdiv_last, fdiv_gap, fref_last, fref_gap, fdiv_first;
    int up_seen, dn_seen;

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, m_cyc);
        end
    endtask

    task automatic drive_rf();
        if (rf_en && m_cyc >= rf_start) rf_in = ((m_cyc - rf_start) % RF_P) < (RF_P / 2);
        else rf_in = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
        chk("R1", "fref_o", int'(fref_o), int'(m_fref));
        chk("R2", "fdiv_o", int'(fdiv_o), int'(m_fdiv));
        chk("R6", "up_o", int'(up_o), int'(m_up && !pump_dis));
        chk("R6", "dn_o", int'(dn_o), int'(m_dn && !pump_dis));
        chk("R8", "lock_oe_o", int'(lock_oe_o), int'(m_good == 4));
        if (fdiv_o) begin
            if (fdiv_first < 0) fdiv_first = m_cyc;
            fdiv_gap = m_cyc - fdiv_last; fdiv_last = m_cyc;
        end
        if (fref_o) begin fref_gap = m_cyc - fref_last; fref_last = m_cyc; end
        if (up_o) up_seen++;
        if (dn_o) dn_seen++;
        drive_rf();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic start_case(bit md, int dv, int start, bit pd);
        rst = 1'b1; rf_en = 0; rf_in = 1'b0;
        mode = md; div = DIV_W'(dv); pump_dis = pd;
        repeat (2) @(negedge clk);
        chk("R10", "fref_o in reset", int'(fref_o), 0);
        chk("R10", "fdiv_o in reset", int'(fdiv_o), 0);
        chk("R10", "up_o/dn_o in reset", int'(up_o | dn_o), 0);
        chk("R10", "lock_oe_o in reset", int'(lock_oe_o), 0);
        rst = 1'b0; rf_en = 1; rf_start = start;
        fdiv_last = 0; fref_last = 0; fdiv_gap = 0; fref_gap = 0;
        fdiv_first = -1; up_seen = 0; dn_seen = 0;
        drive_rf();
    endtask

    initial begin
        void'($urandom(32'd1357));

        // aligned, coarse step: pulses coincide, no requests, lock
        start_case(1, 128, 509, 0);
        run(2200);
        chk("R2", "first fdiv cycle", fdiv_first, 512);
        chk("R1", "fref spacing coarse", fref_gap, 512);
        chk("R6", "coincident pulses give no request", up_seen + dn_seen, 0);
        chk("R8", "lock after clean periods", int'(lock_oe_o), 1);

        // up requests of two cycles are tolerated
        start_case(1, 128, 511, 0);
        run(2200);
        chk("R9", "lock with 2-cycle up", int'(lock_oe_o), 1);

        // up requests of three cycles break lock
        start_case(1, 128, 512, 0);
        run(2200);
        chk("R6", "late feedback raises up", int'(up_seen > 0), 1);
        chk("R9", "no lock with 3-cycle up", int'(lock_oe_o), 0);

        // down requests of two cycles
        start_case(1, 128, 507, 0);
        run(2200);
        chk("R6", "early feedback raises dn", int'(dn_seen > 0), 1);
        chk("R9", "lock with 2-cycle dn", int'(lock_oe_o), 1);

        // coarse step ignores divisor bit 14
        start_case(1, 16'h4000 + 128, 509, 0);
        run(2200);
        chk("R3", "bit 14 ignored in coarse step", int'(lock_oe_o), 1);

        // fine step: 1024 ratio, full divisor
        start_case(0, 256, 1021, 0);
        run(4400);
        chk("R1", "fref spacing fine", fref_gap, 1024);
        chk("R3", "lock in fine step", int'(lock_oe_o), 1);

        start_case(0, 16'h4000 + 256, 1021, 0);
        run(4400);
        chk("R3", "bit 14 counts in fine step", int'(lock_oe_o), 0);

        // tiny divisors
        start_case(1, 0, 0, 0);
        run(60);
        chk("R4", "divisor 0 divides by 2", fdiv_gap, 2 * RF_P);
        start_case(1, 1, 0, 0);
        run(60);
        chk("R4", "divisor 1 divides by 2", fdiv_gap, 2 * RF_P);

        // divisor change mid-cycle
        start_case(1, 128, 509, 0);
        run(1200);
        div = 15'd64;
        run(340);
        chk("R5", "cycle in progress keeps old length", fdiv_gap, 512);
        run(260);
        chk("R5", "new divisor at reload", fdiv_gap, 256);

        // pump disable
        start_case(1, 128, 512, 1);
        run(2200);
        chk("R7", "no up while disabled", up_seen, 0);
        pump_dis = 1'b0; up_seen = 0;
        run(600);
        chk("R7", "up returns when enabled", int'(up_seen > 0), 1);

        // random phase offsets, divisors and modes
        for (int k = 0; k < 8; k++) begin
            bit md;
            int base, nom;
            md = 1'($urandom % 2);
            nom = md ? 128 : 256;
            base = md ? 509 : 1021;
            start_case(md, nom + int'($urandom % 5) - 2, base + int'($urandom % 9) - 4,
                       1'(($urandom % 4) == 0));
            run(md ? 3000 : 5200);
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #600000;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule